// File: doc/BRIEF.md
# Injection Slack Priority Tagger

This block sits in a core's network interface and stamps every outgoing request packet with a 5-bit priority tag at the moment it is injected. The tag estimates how much delay the packet can absorb without hurting the core. A numerically smaller tag means less slack, and so a higher priority in the routers downstream. The block keeps a small table of the core's outstanding load misses. Each entry holds the miss's predicted L2 status, its mesh hop distance and an age counter. The tag of a new packet is derived from the packets already in that table, which are its predecessors.

Injection is a valid/ready stream. A packet is accepted in the cycle where `inj_valid` and `inj_ready` are both high. In that same cycle the tag and the allocated table slot are presented on `inj_tag` and `inj_slot`. `inj_ready` falls while every slot is occupied. A valid presented while ready is low is not accepted and leaves no trace; the source must hold it until ready returns. Response and correction events are plain strobes that name a slot. They carry no handshake.

Top module: `slack_tagger`

## Requirements
- R1: The tag is {miss-level[4:3], l2[2], hop-level[1:0]}. Bit 2 is 0 when the new packet is predicted to miss in L2 (`inj_l2_miss`=1) and 1 when it is predicted to hit.
- R2: The hop count of a packet is |src_x-dst_x| + |src_y-dst_y|.
- R3: Hop slack is the largest hop count among all occupied entries minus the new packet's own hop count. If no entry is occupied, the largest hop count is taken as 0. The hop-level maps slack of 0 or less to 0, slack of 1 to 3 to 1, slack of 4 to 7 to 2, and slack of 8 or more to 3.
- R4: The miss count covers the occupied entries whose L2-miss bit is set and which were injected within the last WIN (32) cycles. An entry counts during the WIN cycles that follow its injection cycle. The count is capped at CNT_CAP (8). The miss-level maps a count of 0 to 0, 1 to 2 to 1, 3 to 5 to 2, and 6 or more to 3.
- R5: The tag and slot are combinational in the acceptance cycle. The packet being injected is never counted as its own predecessor.
- R6: `inj_ready` is low exactly while all DEPTH slots are occupied. A valid presented while ready is low writes nothing. An accepted packet takes the lowest-numbered free slot.
- R7: A `rsp_valid` strobe frees slot `rsp_id` at the next clock edge, so `inj_ready` is high in the following cycle.
- R8: A `cor_valid` strobe overwrites the L2-miss bit of occupied slot `cor_id` with `cor_l2_miss`. A correction aimed at a free slot has no effect.
- R9: After reset the table is empty and `inj_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Packet offered for injection |
| inj_ready | output | 1 | Table has a free slot |
| inj_src_x | input | COORD_W | Source X coordinate |
| inj_src_y | input | COORD_W | Source Y coordinate |
| inj_dst_x | input | COORD_W | Destination X coordinate |
| inj_dst_y | input | COORD_W | Destination Y coordinate |
| inj_l2_miss | input | 1 | Predictor says the packet will miss in L2 |
| inj_tag | output | 5 | Slack priority tag of the offered packet |
| inj_slot | output | $clog2(DEPTH) | Slot the offered packet will occupy |
| rsp_valid | input | 1 | Response returned; frees the slot |
| rsp_id | input | $clog2(DEPTH) | Slot of the returned response |
| cor_valid | input | 1 | L2 status correction notice |
| cor_id | input | $clog2(DEPTH) | Slot being corrected |
| cor_l2_miss | input | 1 | True L2 miss status |

## Verification
The hop tier is tested with one long predecessor followed by shorter packets whose distances fall into each slack band. Some of these use reversed coordinates, which checks that the absolute distance is used and not a signed difference. The miss tier is tested by filling the table with predicted misses, which walks the count through every level boundary and on into back-pressure. An ignored valid and a freed slot show whether acceptance follows ready. A test that waits exactly up to and then just past the 32-cycle window tells the age limit on the miss count apart from the hop maximum, which still includes the aged entry. Corrections are sent to an occupied slot and to a free slot, which separates a correct update from a stray write.

// File: rtl/slack_tag_pkg.sv
package slack_tag_pkg;
  localparam int TAG_W = 5;

  typedef struct packed {
    logic [1:0] miss_lvl;
    logic       l2_hit;
    logic [1:0] hop_lvl;
  } slack_tag_t;

  function automatic logic [1:0] miss_level(input int n);
    if (n <= 0)      return 2'd0;
    else if (n <= 2) return 2'd1;
    else if (n <= 5) return 2'd2;
    else             return 2'd3;
  endfunction

  function automatic logic [1:0] hop_level(input int s);
    if (s <= 0)      return 2'd0;
    else if (s <= 3) return 2'd1;
    else if (s <= 7) return 2'd2;
    else             return 2'd3;
  endfunction
endpackage

// File: rtl/slack_dist.sv
module slack_dist #(
  parameter int COORD_W = 3,
  localparam int HOP_W = COORD_W + 1
) (
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  output logic [HOP_W-1:0]   hops
);
  logic [COORD_W-1:0] ddx, ddy;
  always_comb begin
    ddx  = (sx > dx) ? (sx - dx) : (dx - sx);
    ddy  = (sy > dy) ? (sy - dy) : (dy - sy);
    hops = HOP_W'(ddx) + HOP_W'(ddy);
  end
endmodule

// File: rtl/slack_entry.sv
module slack_entry #(
  parameter int HOP_W = 4,
  parameter int WIN   = 32,
  localparam int AGE_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_miss,
  input  logic [HOP_W-1:0] wr_hops,
  input  logic             free,
  input  logic             cor,
  input  logic             cor_miss,
  output logic             vld,
  output logic             miss,
  output logic [HOP_W-1:0] hops,
  output logic             recent
);
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      miss <= 1'b0;
      hops <= '0;
      age  <= '0;
    end else if (wr) begin
      vld  <= 1'b1;
      miss <= wr_miss;
      hops <= wr_hops;
      age  <= '0;
    end else if (free) begin
      vld  <= 1'b0;
      miss <= 1'b0;
    end else begin
      if (cor && vld) miss <= cor_miss;
      if (vld && age < AGE_W'(WIN)) age <= age + 1'b1;
    end
  end

  assign recent = vld && (age < AGE_W'(WIN));
endmodule

// File: rtl/slack_scan.sv
module slack_scan #(
  parameter int DEPTH   = 8,
  parameter int HOP_W   = 4,
  parameter int CNT_CAP = 8,
  localparam int CW = $clog2(((DEPTH > CNT_CAP) ? DEPTH : CNT_CAP) + 1)
) (
  input  logic [DEPTH-1:0]       vld,
  input  logic [DEPTH-1:0]       miss,
  input  logic [DEPTH-1:0]       recent,
  input  logic [DEPTH*HOP_W-1:0] hops_flat,
  output logic [CW-1:0]          miss_cnt,
  output logic [HOP_W-1:0]       max_hops
);
  logic [CW-1:0] raw;

  always_comb begin
    raw      = '0;
    max_hops = '0;
    for (int i = 0; i < DEPTH; i++) begin
      raw = raw + CW'(vld[i] & miss[i] & recent[i]);
      if (vld[i] && hops_flat[i*HOP_W +: HOP_W] > max_hops)
        max_hops = hops_flat[i*HOP_W +: HOP_W];
    end
    miss_cnt = (raw > CW'(CNT_CAP)) ? CW'(CNT_CAP) : raw;
  end
endmodule

// File: rtl/slack_tagger.sv
module slack_tagger
  import slack_tag_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int COORD_W = 3,
  parameter int WIN     = 32,
  parameter int CNT_CAP = 8,
  localparam int HOP_W = COORD_W + 1,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(((DEPTH > CNT_CAP) ? DEPTH : CNT_CAP) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inj_valid,
  output logic               inj_ready,
  input  logic [COORD_W-1:0] inj_src_x,
  input  logic [COORD_W-1:0] inj_src_y,
  input  logic [COORD_W-1:0] inj_dst_x,
  input  logic [COORD_W-1:0] inj_dst_y,
  input  logic               inj_l2_miss,
  output logic [TAG_W-1:0]   inj_tag,
  output logic [SW-1:0]      inj_slot,
  input  logic               rsp_valid,
  input  logic [SW-1:0]      rsp_id,
  input  logic               cor_valid,
  input  logic [SW-1:0]      cor_id,
  input  logic               cor_l2_miss
);
  logic [DEPTH-1:0]       vld, miss, recent;
  logic [DEPTH*HOP_W-1:0] hops_flat;
  logic [HOP_W-1:0]       own_hops, max_hops;
  logic [CW-1:0]          miss_cnt;
  logic                   fire;
  slack_tag_t             tag;

  slack_dist #(.COORD_W(COORD_W)) u_dist (
    .sx(inj_src_x), .sy(inj_src_y), .dx(inj_dst_x), .dy(inj_dst_y),
    .hops(own_hops)
  );

  // lowest free slot
  always_comb begin
    inj_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) inj_slot = SW'(i);
  end

  assign inj_ready = ~&vld;
  assign fire      = inj_valid && inj_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    slack_entry #(.HOP_W(HOP_W), .WIN(WIN)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (fire && inj_slot == SW'(g)),
      .wr_miss  (inj_l2_miss),
      .wr_hops  (own_hops),
      .free     (rsp_valid && rsp_id == SW'(g)),
      .cor      (cor_valid && cor_id == SW'(g)),
      .cor_miss (cor_l2_miss),
      .vld      (vld[g]),
      .miss     (miss[g]),
      .hops     (hops_flat[g*HOP_W +: HOP_W]),
      .recent   (recent[g])
    );
  end

  slack_scan #(.DEPTH(DEPTH), .HOP_W(HOP_W), .CNT_CAP(CNT_CAP)) u_scan (
    .vld(vld), .miss(miss), .recent(recent), .hops_flat(hops_flat),
    .miss_cnt(miss_cnt), .max_hops(max_hops)
  );

  always_comb begin
    tag.miss_lvl = miss_level(int'(miss_cnt));
    tag.l2_hit   = ~inj_l2_miss;
    tag.hop_lvl  = hop_level(int'(max_hops) - int'(own_hops));
    inj_tag      = tag;
  end
endmodule

// File: rtl/slack_tagger_chk.sv
module slack_tagger_chk
  import slack_tag_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inj_valid,
  input logic             inj_ready,
  input logic [TAG_W-1:0] inj_tag,
  input logic [SW-1:0]    inj_slot,
  input logic             rsp_valid,
  input logic [SW-1:0]    rsp_id
);
  logic [DEPTH-1:0] occ;
  logic             fire;
  assign fire = inj_valid && inj_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rsp_valid && rsp_id == SW'(i)) occ[i] <= 1'b0;
        if (fire && inj_slot == SW'(i))    occ[i] <= 1'b1;
      end
    end
  end

  a_r6_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ready == !(&occ));
  a_r6_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !occ[inj_slot]);
  a_r7_rsp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && occ[rsp_id]) |=> inj_ready);
  a_r5_empty_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && occ == '0) |-> (inj_tag[4:3] == 2'd0 && inj_tag[1:0] == 2'd0));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (inj_tag[4:3] <= miss_level($countones(occ))));
endmodule

bind slack_tagger slack_tagger_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_ready(inj_ready),
  .inj_tag(inj_tag), .inj_slot(inj_slot), .rsp_valid(rsp_valid), .rsp_id(rsp_id)
);

// File: tb/slack_tagger_tb.sv
module slack_tagger_tb;
  localparam int DEPTH = 8;
  localparam int CW_ = 3;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic inj_valid = 0, inj_ready, inj_l2_miss = 0;
  logic [CW_-1:0] inj_src_x = 0, inj_src_y = 0, inj_dst_x = 0, inj_dst_y = 0;
  logic [4:0] inj_tag;
  logic [SW-1:0] inj_slot, rsp_id = 0, cor_id = 0;
  logic rsp_valid = 0, cor_valid = 0, cor_l2_miss = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  slack_tagger #(.DEPTH(DEPTH), .COORD_W(CW_)) u_dut (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_src_x(inj_src_x), .inj_src_y(inj_src_y), .inj_dst_x(inj_dst_x),
    .inj_dst_y(inj_dst_y), .inj_l2_miss(inj_l2_miss), .inj_tag(inj_tag),
    .inj_slot(inj_slot), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .cor_valid(cor_valid), .cor_id(cor_id), .cor_l2_miss(cor_l2_miss)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle per call; entered just after a rising edge
  task automatic inject(int sx, int sy, int dx, int dy, bit pm,
                        int etag, int eslot, string req);
    inj_valid = 1; inj_l2_miss = pm;
    inj_src_x = CW_'(sx); inj_src_y = CW_'(sy);
    inj_dst_x = CW_'(dx); inj_dst_y = CW_'(dy);
    #8;
    chk({req, " ready"}, int'(inj_ready), 1);
    chk({req, " tag"}, int'(inj_tag), etag);
    chk({req, " slot"}, int'(inj_slot), eslot);
    @(posedge clk); #1;
    inj_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic respond(int id);
    rsp_valid = 1; rsp_id = SW'(id);
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic correct(int id, bit m);
    cor_valid = 1; cor_id = SW'(id); cor_l2_miss = m;
    @(posedge clk); #1;
    cor_valid = 0;
  endtask

  task automatic clear(int n);
    for (int i = 0; i < n; i++) respond(i);
  endtask

  task automatic t_reset;
    #8;
    chk("R9 ready after reset", int'(inj_ready), 1);
    idle(1);
  endtask

  task automatic t_hop_slack;
    inject(0, 0, 7, 7, 0, 5'b00100, 0, "R5 empty table");
    inject(0, 0, 1, 0, 0, 5'b00111, 1, "R3 slack 13");
    inject(0, 0, 5, 5, 0, 5'b00110, 2, "R3 slack 4");
    inject(0, 0, 7, 7, 0, 5'b00100, 3, "R3 slack 0");
    inject(7, 6, 0, 4, 0, 5'b00110, 4, "R2 reversed slack 5");
    inject(5, 7, 2, 7, 1, 5'b00011, 5, "R1 miss bit slack 11");
    clear(6);
  endtask

  task automatic t_miss_count;
    int exp_lvl[8] = '{0, 1, 1, 2, 2, 2, 3, 3};
    for (int k = 0; k < 8; k++)
      inject(0, 0, 1, 1, 1, exp_lvl[k] << 3, k, "R4 miss count");
    #8;
    chk("R6 full ready", int'(inj_ready), 0);
    idle(0);
    inj_valid = 1; inj_l2_miss = 1;
    @(posedge clk); #1;
    inj_valid = 0;
    #8;
    chk("R6 ignored while full", int'(inj_ready), 0);
    idle(0);
    respond(3);
    #8;
    chk("R7 ready after response", int'(inj_ready), 1);
    idle(0);
    inject(0, 0, 1, 1, 1, 5'b11000, 3, "R6 refill lowest slot");
    clear(8);
  endtask

  task automatic t_window;
    inject(0, 0, 1, 1, 1, 5'b00000, 0, "R4 window A");
    idle(31);
    inject(0, 0, 1, 1, 0, 5'b01100, 1, "R4 last window cycle");
    inject(0, 0, 0, 1, 0, 5'b00101, 2, "R4 aged out, R3 hop max kept");
    clear(3);
  endtask

  task automatic t_correct;
    inject(0, 0, 1, 1, 0, 5'b00100, 0, "R8 base");
    correct(0, 1);
    inject(0, 0, 1, 1, 0, 5'b01100, 1, "R8 set by correction");
    correct(0, 0);
    correct(5, 1);
    inject(0, 0, 1, 1, 0, 5'b00100, 2, "R8 cleared, free slot ignored");
    clear(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_hop_slack;
    t_miss_count;
    t_window;
    t_correct;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule